// File: doc/BRIEF.md
# Positive Justification Tributary Multiplexer

This block merges four plesiochronous low-rate bit streams into one higher-order line frame. Each tributary presents one bit at a time on its own write strobe and the bit goes into a 16-entry elastic FIFO belonging to that tributary. The line side emits one frame bit per clock: an 848-bit frame made of four blocks of 212 bits. The tributaries take turns, one payload bit each, in a fixed lane order.

Rate differences between the tributaries and the line are absorbed by positive justification. At the first bit of every frame the block samples each FIFO's fill level. A tributary whose fill is below the threshold gets an empty bit in its single justification opportunity in the last block. A tributary at or above the threshold gets a payload bit there. The decision is announced three times so that a receiver can take a majority vote. FIFO overflow and underflow are recorded in a sticky error flag per tributary.

Top module: `pj_trib_mux`

## Requirements
- R1: The line output repeats an 848-bit frame of four 212-bit blocks. `frame_start` is high exactly while the first frame bit is on `line_bit`. Block offsets 0..9 of the first block carry the alignment word, most significant bit first, with default 1111010000. Offsets 10..11 carry the service bits, which default to 00.
- R2: Every payload bit at block offset k carries the next FIFO bit of tributary k mod 4. Each tributary's bits leave in the order they were written.
- R3: Offsets 0..3 of blocks two, three and four carry the justification control bit of tributaries 0..3, in that order. A tributary's control bit has the same value in all three blocks of a frame.
- R4: A tributary whose FIFO fill is below 8 at the frame's first bit has control bit 1 for that frame. Otherwise its control bit is 0. Both outcomes occur when the tributary's write rate sits between the stuffed and unstuffed read rates.
- R5: Offsets 4..7 of block four are the justification opportunities of tributaries 0..3. With control bit 1 the opportunity carries 0 and consumes nothing. With control bit 0 it carries that tributary's next FIFO bit.
- R6: After reset, while reset is held, `line_bit`, `frame_start` and `trib_err` are 0. The first clock edge after reset is released puts frame bit 0 on the line.
- R7: A write into a full FIFO is dropped and sets that tributary's error flag.
- R8: A read from an empty FIFO puts 0 on the line and sets that tributary's error flag. Error flags stay set until reset and do not affect the other tributaries.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Line-rate clock; one frame bit per cycle |
| rst | input | 1 | Synchronous active-high reset |
| trib_we | input | 4 | Per-tributary write strobe |
| trib_bit | input | 4 | Per-tributary data bit, taken when its strobe is high |
| line_bit | output | 1 | Registered multiplexed frame bit |
| frame_start | output | 1 | High with frame bit 0 |
| trib_err | output | 4 | Sticky overflow/underflow flag per tributary |

## Verification
A frame slot is decoded in one cycle, and its bit appears on `line_bit` one edge later, in step with `frame_start`. The monitor therefore samples on the falling edge and tracks slot positions from the observed `frame_start`, without predicting them from reset. The fill snapshot taken at a frame's first edge first shows on the line 212 cycles later, in block two. Because the bench's own fill count lags the hardware by a write or a read, the loose policy check only judges fills at least three entries away from the threshold. Frame zero is checked exactly, since every FIFO is empty at its first edge. Error flags rise one edge after the offending strobe, and the bench reads them only at phase boundaries, long after that edge.

// File: rtl/pj_mux_pkg.sv
package pj_mux_pkg;
  localparam int unsigned LANES = 4;

  typedef enum logic [2:0] {
    SL_ALIGN,
    SL_SERV,
    SL_CTRL,
    SL_OPP,
    SL_DATA
  } slot_e;
endpackage

// File: rtl/pj_elastic_fifo.sv
module pj_elastic_fifo #(
  parameter int unsigned DEPTH = 16,
  localparam int unsigned PW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic          wr_bit,
  input  logic          rd_en,
  output logic          rd_bit,
  output logic [CW-1:0] fill,
  output logic          err
);
  logic [DEPTH-1:0] mem;
  logic [PW-1:0]    wp, rp;
  logic             full, empty, do_wr, do_rd;

  localparam logic [CW-1:0] FULL_CNT = CW'(DEPTH);
  localparam logic [PW-1:0] LAST_PTR = PW'(DEPTH - 1);

  assign full  = (fill == FULL_CNT);
  assign empty = (fill == '0);
  assign do_wr = wr_en && !full;
  assign do_rd = rd_en && !empty;
  assign rd_bit = mem[rp] & !empty;

  // storage without reset so it maps onto distributed RAM
  always_ff @(posedge clk) begin
    if (do_wr) mem[wp] <= wr_bit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp   <= '0;
      rp   <= '0;
      fill <= '0;
      err  <= 1'b0;
    end else begin
      if (do_wr) wp <= (wp == LAST_PTR) ? '0 : wp + 1'b1;
      if (do_rd) rp <= (rp == LAST_PTR) ? '0 : rp + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   fill <= fill + 1'b1;
        2'b01:   fill <= fill - 1'b1;
        default: fill <= fill;
      endcase
      if ((wr_en && full) || (rd_en && empty)) err <= 1'b1;
    end
  end

  p_fill_bound_r7: assert property (@(posedge clk) disable iff (rst)
    fill <= FULL_CNT);
  p_over_flag_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full) |=> err);
  p_over_drop_r7: assert property (@(posedge clk) disable iff (rst)
    (wr_en && full && !rd_en) |=> (fill == FULL_CNT));
  p_under_flag_r8: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> err);
  p_err_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    err |=> err);
endmodule

// File: rtl/pj_frame_seq.sv
module pj_frame_seq #(
  parameter int unsigned BLOCK_LEN = 212,
  parameter int unsigned NUM_BLK   = 4,
  localparam int unsigned OW = $clog2(BLOCK_LEN),
  localparam int unsigned BW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1
) (
  input  logic          clk,
  input  logic          rst,
  output logic [BW-1:0] blk,
  output logic [OW-1:0] off,
  output logic          at_start
);
  localparam logic [OW-1:0] OFF_LAST = OW'(BLOCK_LEN - 1);
  localparam logic [BW-1:0] BLK_LAST = BW'(NUM_BLK - 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      blk <= '0;
      off <= '0;
    end else if (off == OFF_LAST) begin
      off <= '0;
      blk <= (blk == BLK_LAST) ? '0 : blk + 1'b1;
    end else begin
      off <= off + 1'b1;
    end
  end

  assign at_start = (blk == '0) && (off == '0);

  p_off_range_r1: assert property (@(posedge clk) disable iff (rst)
    off <= OFF_LAST);
  p_block_step_r1: assert property (@(posedge clk) disable iff (rst)
    (off == OFF_LAST) |=> (off == '0));
endmodule

// File: rtl/pj_slot_decode.sv
module pj_slot_decode
  import pj_mux_pkg::*;
#(
  parameter int unsigned OW        = 8,
  parameter int unsigned BW        = 2,
  parameter int unsigned ALIGN_LEN = 10,
  parameter int unsigned SERV_LEN  = 2,
  parameter int unsigned LAST_BLK  = 3,
  localparam int unsigned LW = $clog2(LANES)
) (
  input  logic [BW-1:0] blk,
  input  logic [OW-1:0] off,
  output slot_e         kind,
  output logic [LW-1:0] lane
);
  localparam logic [OW-1:0] ALIGN_END = OW'(ALIGN_LEN);
  localparam logic [OW-1:0] SERV_END  = OW'(ALIGN_LEN + SERV_LEN);
  localparam logic [OW-1:0] CTRL_END  = OW'(LANES);
  localparam logic [OW-1:0] OPP_END   = OW'(2 * LANES);
  localparam logic [BW-1:0] BLK_OPP   = BW'(LAST_BLK);

  assign lane = off[LW-1:0];

  always_comb begin
    if (blk == '0) begin
      if (off < ALIGN_END)     kind = SL_ALIGN;
      else if (off < SERV_END) kind = SL_SERV;
      else                     kind = SL_DATA;
    end else begin
      if (off < CTRL_END)                       kind = SL_CTRL;
      else if (blk == BLK_OPP && off < OPP_END) kind = SL_OPP;
      else                                      kind = SL_DATA;
    end
  end
endmodule

// File: rtl/pj_trib_mux.sv
module pj_trib_mux
  import pj_mux_pkg::*;
#(
  parameter int unsigned BLOCK_LEN    = 212,
  parameter int unsigned NUM_BLK      = 4,
  parameter int unsigned FIFO_DEPTH   = 16,
  parameter int unsigned STUFF_THRESH = 8,
  parameter int unsigned ALIGN_LEN    = 10,
  parameter logic [ALIGN_LEN-1:0] ALIGN_WORD = 10'b1111010000,
  parameter int unsigned SERV_LEN     = 2,
  parameter logic [SERV_LEN-1:0] SERV_BITS = '0
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LANES-1:0] trib_we,
  input  logic [LANES-1:0] trib_bit,
  output logic             line_bit,
  output logic             frame_start,
  output logic [LANES-1:0] trib_err
);
  localparam int unsigned OW = $clog2(BLOCK_LEN);
  localparam int unsigned BW = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
  localparam int unsigned CW = $clog2(FIFO_DEPTH + 1);
  localparam int unsigned LW = $clog2(LANES);
  localparam int unsigned AW = (ALIGN_LEN > 1) ? $clog2(ALIGN_LEN) : 1;
  localparam int unsigned SW = (SERV_LEN > 1) ? $clog2(SERV_LEN) : 1;
  localparam logic [CW-1:0] THR = CW'(STUFF_THRESH);

  logic [BW-1:0]    blk;
  logic [OW-1:0]    off;
  logic             at_start;
  slot_e            kind;
  logic [LW-1:0]    lane;
  logic [LANES-1:0] rd_en, rd_bit, stuff_now, stuff_q;
  logic [CW-1:0]    fill [LANES];
  logic [AW-1:0]    a_idx;
  logic [SW-1:0]    s_idx;
  logic             nxt_bit;

  pj_frame_seq #(.BLOCK_LEN(BLOCK_LEN), .NUM_BLK(NUM_BLK)) u_seq (
    .clk(clk), .rst(rst), .blk(blk), .off(off), .at_start(at_start)
  );

  pj_slot_decode #(
    .OW(OW), .BW(BW), .ALIGN_LEN(ALIGN_LEN), .SERV_LEN(SERV_LEN), .LAST_BLK(NUM_BLK - 1)
  ) u_dec (
    .blk(blk), .off(off), .kind(kind), .lane(lane)
  );

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign rd_en[g] = (lane == LW'(g)) &&
                      ((kind == SL_DATA) || (kind == SL_OPP && !stuff_q[g]));
    assign stuff_now[g] = (fill[g] < THR);

    pj_elastic_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
      .clk(clk), .rst(rst),
      .wr_en(trib_we[g]), .wr_bit(trib_bit[g]),
      .rd_en(rd_en[g]), .rd_bit(rd_bit[g]),
      .fill(fill[g]), .err(trib_err[g])
    );
  end

  assign a_idx = AW'(ALIGN_LEN - 1) - AW'(off);
  assign s_idx = SW'(SERV_LEN - 1) - SW'(off - OW'(ALIGN_LEN));

  always_comb begin
    case (kind)
      SL_ALIGN: nxt_bit = ALIGN_WORD[a_idx];
      SL_SERV:  nxt_bit = SERV_BITS[s_idx];
      SL_CTRL:  nxt_bit = stuff_q[lane];
      SL_OPP:   nxt_bit = stuff_q[lane] ? 1'b0 : rd_bit[lane];
      default:  nxt_bit = rd_bit[lane];
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      line_bit    <= 1'b0;
      frame_start <= 1'b0;
      stuff_q     <= '1;
    end else begin
      line_bit    <= nxt_bit;
      frame_start <= at_start;
      if (at_start) stuff_q <= stuff_now;
    end
  end

  p_start_pulse_r1: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> !frame_start);
  p_decision_held_r3: assert property (@(posedge clk) disable iff (rst)
    (blk != '0) |-> $stable(stuff_q));
  p_stuff_empty_r5: assert property (@(posedge clk) disable iff (rst)
    (kind == SL_OPP && stuff_q[lane]) |=> !line_bit);
  p_one_reader_r2: assert property (@(posedge clk) disable iff (rst)
    $onehot0(rd_en));
endmodule

// File: tb/test_pj_trib_mux.sv
module test_pj_trib_mux;
  localparam int CLK_PERIOD  = 10;
  localparam int BLK_LEN     = 212;
  localparam int FRAME_LEN   = 4 * BLK_LEN;
  localparam int NT          = 4;
  localparam logic [9:0] AWORD = 10'b1111010000;
  localparam int RATE_NUM    = 411;
  localparam int RATE_DEN    = 1696;
  localparam int FAULT_START = 6 * FRAME_LEN;
  localparam int RUN_END     = FAULT_START + 2 * FRAME_LEN;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NT-1:0] trib_we  = '0;
  logic [NT-1:0] trib_bit = '0;
  logic line_bit, frame_start;
  logic [NT-1:0] trib_err;

  int total = 0;
  int bad = 0;
  bit finished = 0;
  bit sb_on = 1;
  bit under_chk = 0;
  bit exp_q [NT][$];
  int snap [NT];
  bit ctrl [4][NT];
  int n_stuff [NT];
  int n_send [NT];
  bit started = 0;
  int pos = 0;
  int frame_no = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pj_trib_mux i_pj_trib_mux (
    .clk(clk), .rst(rst), .trib_we(trib_we), .trib_bit(trib_bit),
    .line_bit(line_bit), .frame_start(frame_start), .trib_err(trib_err)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic summary();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  // monitor / scoreboard
  task automatic do_slot();
    int b, o, ln;
    bit e;
    b = pos / BLK_LEN;
    o = pos % BLK_LEN;
    ln = o % NT;
    if (pos == 0)
      for (int i = 0; i < NT; i++) snap[i] = exp_q[i].size();
    if (b == 0 && o < 10) begin
      chk(line_bit == AWORD[9 - o], "R1 align word", line_bit, AWORD[9 - o]);
    end else if (b == 0 && o < 12) begin
      chk(line_bit == 1'b0, "R1 service bit", line_bit, 0);
    end else if (b > 0 && o < NT) begin
      ctrl[b][ln] = line_bit;
      if (b == 1) begin
        if (frame_no == 0)
          chk(line_bit == 1'b1, "R4 first frame stuff", line_bit, 1);
        else if (sb_on && snap[ln] <= 5)
          chk(line_bit == 1'b1, "R4 low fill control", line_bit, 1);
        else if (sb_on && snap[ln] >= 11)
          chk(line_bit == 1'b0, "R4 high fill control", line_bit, 0);
      end
      if (b == 3)
        chk(ctrl[1][ln] == ctrl[2][ln] && ctrl[2][ln] == ctrl[3][ln],
            "R3 control repeated", {ctrl[1][ln], ctrl[2][ln], ctrl[3][ln]},
            {3{ctrl[3][ln]}});
    end else if (b == 3 && o < 2 * NT) begin
      if (sb_on) begin
        if (ctrl[3][ln]) begin
          n_stuff[ln]++;
          chk(line_bit == 1'b0, "R5 empty opportunity", line_bit, 0);
        end else begin
          n_send[ln]++;
          if (exp_q[ln].size() == 0) chk(0, "R5 opportunity queue empty", line_bit, -1);
          else begin
            e = exp_q[ln].pop_front();
            chk(line_bit == e, "R5 opportunity payload", line_bit, e);
          end
        end
      end
    end else begin
      if (sb_on) begin
        if (exp_q[ln].size() == 0) chk(0, "R2 payload queue empty", line_bit, -1);
        else begin
          e = exp_q[ln].pop_front();
          chk(line_bit == e, "R2 payload order", line_bit, e);
        end
      end
      if (under_chk && ln == 2)
        chk(line_bit == 1'b0, "R8 underflow emits zero", line_bit, 0);
    end
  endtask

  always @(negedge clk) begin
    if (rst) begin
      started = 0;
    end else if (!started) begin
      if (frame_start) begin
        started = 1;
        pos = 0;
        frame_no = 0;
        do_slot();
      end
    end else begin
      pos = (pos == FRAME_LEN - 1) ? 0 : pos + 1;
      if (pos == 0) frame_no++;
      if (pos == 0 || frame_start)
        chk(frame_start == (pos == 0), "R1 frame period", frame_start, pos == 0);
      do_slot();
    end
  end

  // driver
  initial begin
    int acc [NT];
    logic [15:0] lf;
    logic [NT-1:0] w, d;
    lf = 16'hACE1;
    for (int i = 0; i < NT; i++) begin
      acc[i] = i * 400;
      n_stuff[i] = 0;
      n_send[i] = 0;
    end
    repeat (3) @(negedge clk);
    chk(line_bit == 1'b0, "R6 reset line", line_bit, 0);
    chk(frame_start == 1'b0, "R6 reset frame_start", frame_start, 0);
    chk(trib_err == '0, "R6 reset error flags", trib_err, 0);
    rst = 1'b0;
    for (int c = 0; c < RUN_END; c++) begin
      if (c == FAULT_START) begin
        chk(trib_err == '0, "R8 no error in balanced run", trib_err, 0);
        for (int i = 0; i < NT; i++) begin
          chk(n_stuff[i] > 0, "R4 stuffed frames seen", n_stuff[i], 1);
          chk(n_send[i] > 0, "R4 data opportunities seen", n_send[i], 1);
        end
        sb_on = 0;
      end
      if (c == FAULT_START + FRAME_LEN) under_chk = 1;
      for (int i = 0; i < NT; i++) begin
        lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
        d[i] = lf[0];
        if (c < 8) w[i] = 1'b1;
        else begin
          acc[i] += RATE_NUM;
          w[i] = (acc[i] >= RATE_DEN);
          if (w[i]) acc[i] -= RATE_DEN;
        end
        if (c >= FAULT_START && i == 2) w[i] = 1'b0;
        if (c >= FAULT_START && i == 1) w[i] = 1'b1;
        if (w[i] && sb_on) exp_q[i].push_back(d[i]);
      end
      trib_we  = w;
      trib_bit = d;
      if (c == 0) begin
        @(negedge clk);
        chk(frame_start == 1'b1, "R6 first frame after reset", frame_start, 1);
        chk(line_bit == AWORD[9], "R6 first frame bit", line_bit, AWORD[9]);
      end else begin
        @(negedge clk);
      end
    end
    trib_we = '0;
    chk(trib_err[1] == 1'b1, "R7 overflow flag", trib_err[1], 1);
    chk(trib_err[2] == 1'b1, "R8 underflow flag", trib_err[2], 1);
    chk(trib_err[0] == 1'b0 && trib_err[3] == 1'b0, "R8 flags isolated",
        {trib_err[3], trib_err[0]}, 0);
    repeat (20) @(negedge clk);
    chk(trib_err == 4'b0110, "R8 flags sticky", trib_err, 4'b0110);
    finished = 1;
    summary();
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      summary();
    end
  end
endmodule